// File: doc/BRIEF.md
# Two-Port Lane-Masked Synchronous RAM

This block is a synchronous RAM with two symmetric access ports, A and B, that share one clock. In every cycle each port can either read or write any word. A word is split into equal lanes, and a write stores only the lanes whose enable bit is set. Each port has a clock enable and an asynchronous clear for its own registers.

All port inputs are captured in input registers. On the following enabled edge the storage is written and the port's output register is loaded. A writing port sees the data it has just written. A port that reads a word the other port writes on the same edge sees the contents from before that write. When both ports hold pending writes to the same address, a collision flag is raised. The stored word is then undefined, and the logic around the RAM has to deal with it.

Top module: `tdp_be_ram`

## Requirements
- R1: A word is LANES lanes of LANE_W bits each, and the RAM holds DEPTH words. By default there are two 9-bit lanes (18-bit words) and 256 words. Lane l occupies word bits [l*LANE_W +: LANE_W], so lane 0 is bits 8..0 and lane 1 is bits 17..9.
- R2: A port captures address, data, write enable and lane enables on an edge where its clock enable is high. The storage access and the output register update happen on the next edge where the clock enable is high. A read therefore returns the stored word two enabled edges after the address is presented.
- R3: A write changes only the lanes whose lane-enable bit is 1. Every lane-enable combination is accepted, including none. Masked lanes keep their earlier value.
- R4: On a write, the writing port's output shows the new data in its enabled lanes. Its masked lanes show the contents stored before the write.
- R5: When one port reads a word that the other port writes on the same edge, the reading port's output shows the contents from before that write.
- R6: `collide` is 1 exactly while both ports hold captured writes to the same address, and 0 otherwise. After such a collision the stored word is undefined until a full-word write replaces it.
- R7: While a port's clock enable is 0, that port captures no inputs, performs no write and holds its output.
- R8: While a port's clear is high, its output is 0, any pending write is discarded and its lane-enable register holds all ones. This is also the state after power-up, whatever the storage holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| aclr_a | input | 1 | Port A asynchronous clear of its registers, active high |
| cen_a | input | 1 | Port A clock enable |
| wen_a | input | 1 | Port A write request |
| be_a | input | LANES | Port A lane enables, bit l selects lane l |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | LANES*LANE_W | Port A write data |
| dout_a | output | LANES*LANE_W | Port A registered output |
| aclr_b | input | 1 | Port B asynchronous clear of its registers, active high |
| cen_b | input | 1 | Port B clock enable |
| wen_b | input | 1 | Port B write request |
| be_b | input | LANES | Port B lane enables, bit l selects lane l |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | LANES*LANE_W | Port B write data |
| dout_b | output | LANES*LANE_W | Port B registered output |
| collide | output | 1 | Both ports hold pending writes to one address |

## Verification
The assertions assume that each clear is raised and lowered away from the active clock edge, so that a register is never cleared in the same instant it loads. They also assume that a clear stays high for a whole cycle before the first enabled edge. The bench changes every input only on falling edges and holds each clear for at least one full cycle. Contents read back after a collision are never taken as a reference: the bench marks that word unknown until a full-word write replaces it.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
    // default geometry shared by the RAM and its port slices
    localparam int DEF_LANE_W = 9;
    localparam int DEF_LANES  = 2;
    localparam int DEF_DEPTH  = 256;
endpackage

// File: rtl/tdp_lane_merge.sv
module tdp_lane_merge #(
    parameter int LANE_W = tdp_pkg::DEF_LANE_W,
    parameter int LANES  = tdp_pkg::DEF_LANES,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic [WORD_W-1:0] new_i,
    input  logic [WORD_W-1:0] old_i,
    input  logic [LANES-1:0]  lane_en_i,
    output logic [WORD_W-1:0] merged_o
);
    // each lane takes the new data when enabled, else the stored contents
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged_o[l*LANE_W +: LANE_W] = lane_en_i[l] ? new_i[l*LANE_W +: LANE_W]
                                                           : old_i[l*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/tdp_port.sv
module tdp_port #(
    parameter int LANE_W = tdp_pkg::DEF_LANE_W,
    parameter int LANES  = tdp_pkg::DEF_LANES,
    parameter int ADDR_W = 8,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk_i,
    input  logic              aclr_i,
    input  logic              cen_i,
    input  logic              wen_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] din_i,
    input  logic [WORD_W-1:0] rd_word_i,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [WORD_W-1:0] din_q_o,
    output logic              wen_q_o,
    output logic [LANES-1:0]  be_q_o,
    output logic              wr_go_o,
    output logic [WORD_W-1:0] dout_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] din;
        logic              wen;
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] dout;
    } port_state_t;

    port_state_t st_d, st_q;
    logic [WORD_W-1:0] thru_word;

    tdp_lane_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
        .new_i    (st_q.din),
        .old_i    (rd_word_i),
        .lane_en_i(st_q.be),
        .merged_o (thru_word)
    );

    always_comb begin
        st_d = st_q;
        if (cen_i) begin
            st_d.addr = addr_i;
            st_d.din  = din_i;
            st_d.wen  = wen_i;
            st_d.be   = be_i;
            st_d.dout = st_q.wen ? thru_word : rd_word_i;
        end
    end

    always_ff @(posedge clk_i or posedge aclr_i) begin
        if (aclr_i) begin
            st_q    <= '0;
            st_q.be <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_q_o = st_q.addr;
    assign din_q_o  = st_q.din;
    assign wen_q_o  = st_q.wen;
    assign be_q_o   = st_q.be;
    assign wr_go_o  = st_q.wen & cen_i;
    assign dout_o   = st_q.dout;

    // R8
    clr_state_chk: assert property (@(posedge clk_i)
        aclr_i |-> (dout_o == '0 && be_q_o == '1 && !wen_q_o));

    // R7
    cen_hold_chk: assert property (@(posedge clk_i) disable iff (aclr_i)
        !cen_i |=> $stable(dout_o) && $stable(addr_q_o));

    // R4
    thru_full_chk: assert property (@(posedge clk_i) disable iff (aclr_i)
        (cen_i && wen_q_o && be_q_o == '1) |=> (dout_o == $past(din_q_o)));

    // R2
    read_word_chk: assert property (@(posedge clk_i) disable iff (aclr_i)
        (cen_i && !wen_q_o) |=> (dout_o == $past(rd_word_i)));
endmodule

// File: rtl/tdp_be_ram.sv
module tdp_be_ram #(
    parameter int LANE_W = tdp_pkg::DEF_LANE_W,
    parameter int LANES  = tdp_pkg::DEF_LANES,
    parameter int DEPTH  = tdp_pkg::DEF_DEPTH,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              aclr_a,
    input  logic              cen_a,
    input  logic              wen_a,
    input  logic [LANES-1:0]  be_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [WORD_W-1:0] din_a,
    output logic [WORD_W-1:0] dout_a,
    input  logic              aclr_b,
    input  logic              cen_b,
    input  logic              wen_b,
    input  logic [LANES-1:0]  be_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [WORD_W-1:0] din_b,
    output logic [WORD_W-1:0] dout_b,
    output logic              collide
);
    logic [WORD_W-1:0] mem [DEPTH];

    logic [ADDR_W-1:0] addr_qa, addr_qb;
    logic [WORD_W-1:0] din_qa, din_qb;
    logic              wen_qa, wen_qb;
    logic [LANES-1:0]  be_qa, be_qb;
    logic              go_a, go_b;
    logic [WORD_W-1:0] rd_a, rd_b;

    assign rd_a = mem[addr_qa];
    assign rd_b = mem[addr_qb];

    tdp_port #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_port_a (
        .clk_i    (clk),
        .aclr_i   (aclr_a),
        .cen_i    (cen_a),
        .wen_i    (wen_a),
        .be_i     (be_a),
        .addr_i   (addr_a),
        .din_i    (din_a),
        .rd_word_i(rd_a),
        .addr_q_o (addr_qa),
        .din_q_o  (din_qa),
        .wen_q_o  (wen_qa),
        .be_q_o   (be_qa),
        .wr_go_o  (go_a),
        .dout_o   (dout_a)
    );

    tdp_port #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_port_b (
        .clk_i    (clk),
        .aclr_i   (aclr_b),
        .cen_i    (cen_b),
        .wen_i    (wen_b),
        .be_i     (be_b),
        .addr_i   (addr_b),
        .din_i    (din_b),
        .rd_word_i(rd_b),
        .addr_q_o (addr_qb),
        .din_q_o  (din_qb),
        .wen_q_o  (wen_qb),
        .be_q_o   (be_qb),
        .wr_go_o  (go_b),
        .dout_o   (dout_b)
    );

    // storage: one edge serves both ports; per-lane masked writes
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (go_a && be_qa[l]) mem[addr_qa][l*LANE_W +: LANE_W] <= din_qa[l*LANE_W +: LANE_W];
            if (go_b && be_qb[l]) mem[addr_qb][l*LANE_W +: LANE_W] <= din_qb[l*LANE_W +: LANE_W];
        end
    end

    assign collide = wen_qa & wen_qb & (addr_qa == addr_qb);

    // R6
    collide_flag_chk: assert property (@(posedge clk) disable iff (aclr_a || aclr_b)
        (cen_a && cen_b && wen_a && wen_b && addr_a == addr_b) |=> collide);

    // R6
    collide_quiet_chk: assert property (@(posedge clk) disable iff (aclr_a || aclr_b)
        (cen_a && cen_b && !(wen_a && wen_b)) |=> !collide);
endmodule

// File: tb/tb_tdp_be_ram.sv
`timescale 1ns/1ps
module tb_tdp_be_ram;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        aclr_a, cen_a, wen_a, aclr_b, cen_b, wen_b;
    logic [1:0]  be_a, be_b;
    logic [7:0]  addr_a, addr_b;
    logic [17:0] din_a, din_b, dout_a, dout_b;
    logic        collide;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [17:0] m [256];
    bit          v [256];

    always #(HALF) clk = ~clk;

    tdp_be_ram dut (
        .clk(clk),
        .aclr_a(aclr_a), .cen_a(cen_a), .wen_a(wen_a), .be_a(be_a),
        .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
        .aclr_b(aclr_b), .cen_b(cen_b), .wen_b(wen_b), .be_b(be_b),
        .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b),
        .collide(collide)
    );

    function automatic logic [17:0] mrg(input logic [17:0] nw, input logic [17:0] old,
                                        input logic [1:0] be);
        logic [17:0] r;
        r = old;
        if (be[0]) r[8:0]  = nw[8:0];
        if (be[1]) r[17:9] = nw[17:9];
        return r;
    endfunction

    function automatic logic [17:0] pat(input int x);
        return 18'((x * 1237) ^ 32'h2A5C5);
    endfunction

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one operation on each port: drive, sample collide, sample outputs
    task automatic op(input bit wa, input logic [1:0] ba, input int aa, input logic [17:0] da,
                      input bit wb, input logic [1:0] bb, input int ab, input logic [17:0] db,
                      input string tag);
        logic [17:0] ea, eb;
        bit ca, cb, coll;
        coll = wa && wb && (aa == ab);
        ca = v[aa] || (wa && ba == 2'b11);
        cb = v[ab] || (wb && bb == 2'b11);
        ea = wa ? mrg(da, m[aa], ba) : m[aa];
        eb = wb ? mrg(db, m[ab], bb) : m[ab];
        @(negedge clk);
        wen_a = wa; be_a = ba; addr_a = 8'(aa); din_a = da;
        wen_b = wb; be_b = bb; addr_b = 8'(ab); din_b = db;
        @(negedge clk);
        chk("R6 collide", {17'b0, collide}, {17'b0, coll});
        wen_a = 1'b0; wen_b = 1'b0;
        @(negedge clk);
        if (ca) chk({tag, " port A"}, dout_a, ea);
        if (cb) chk({tag, " port B"}, dout_b, eb);
        if (wa) m[aa] = mrg(da, m[aa], ba);
        if (wb) m[ab] = mrg(db, m[ab], bb);
        if (wa && ba == 2'b11) v[aa] = 1;
        if (wb && bb == 2'b11) v[ab] = 1;
        if (coll) v[aa] = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) v[i] = 0;
        aclr_a = 1; aclr_b = 1; cen_a = 1; cen_b = 1;
        wen_a = 0; wen_b = 0; be_a = 2'b11; be_b = 2'b11;
        addr_a = 0; addr_b = 0; din_a = 0; din_b = 0;
        repeat (3) @(negedge clk);
        // R8: outputs clear from power-up
        chk("R8 reset dout_a", dout_a, 18'h0);
        chk("R8 reset dout_b", dout_b, 18'h0);
        chk("R8 reset collide", {17'b0, collide}, 18'h0);
        aclr_a = 0; aclr_b = 0;

        // R1 R4: full-word writes on both ports, disjoint addresses
        for (int i = 0; i < 128; i++)
            op(1, 2'b11, 2*i, pat(2*i), 1, 2'b11, 2*i+1, pat(2*i+1), "R1 R4 write");

        // R2: read back every word from both ports
        for (int i = 0; i < 256; i++)
            op(0, 2'b00, i, 18'h0, 0, 2'b00, 255-i, 18'h0, "R2 read");

        // R3 R4 R5: every lane-enable pattern; B reads the word A writes
        for (int i = 0; i < 64; i++)
            op(1, 2'(i % 4), i, ~pat(i + 500), 0, 2'b00, i, 18'h0, "R3 R4 R5 masked");
        for (int i = 0; i < 64; i++)
            op(0, 2'b00, i + 64, 18'h0, 0, 2'b00, i, 18'h0, "R3 readback");

        // R6: same-address dual write, then recovery by a full write
        op(1, 2'b11, 200, 18'h155AA, 1, 2'b11, 200, 18'h2AA55, "R6 dual write");
        op(1, 2'b01, 200, 18'h00123, 0, 2'b00, 201, 18'h0, "R6 partial");
        op(1, 2'b11, 200, 18'h3C3C3, 0, 2'b00, 200, 18'h0, "R6 rewrite");
        op(0, 2'b00, 201, 18'h0, 0, 2'b00, 200, 18'h0, "R6 recovered");
        op(1, 2'b11, 210, 18'h11111, 0, 2'b00, 210, 18'h0, "R6 one writer");

        // R7: clock enable low blocks capture, write and output update
        op(0, 2'b00, 5, 18'h0, 0, 2'b00, 6, 18'h0, "R7 preread");
        @(negedge clk);
        cen_a = 0; wen_a = 1; be_a = 2'b11; addr_a = 8'd5; din_a = ~m[5];
        @(negedge clk);
        wen_a = 0;
        @(negedge clk);
        chk("R7 output held", dout_a, m[5]);
        cen_a = 1;
        op(0, 2'b00, 5, 18'h0, 0, 2'b00, 5, 18'h0, "R7 no write");

        // R8: clear discards a captured write and zeroes the output
        @(negedge clk);
        wen_a = 1; be_a = 2'b11; addr_a = 8'd9; din_a = ~m[9];
        @(negedge clk);
        aclr_a = 1; wen_a = 0;
        #1;
        chk("R8 clear dout", dout_a, 18'h0);
        @(negedge clk);
        chk("R8 clear held", dout_a, 18'h0);
        aclr_a = 0;
        op(0, 2'b00, 9, 18'h0, 0, 2'b00, 9, 18'h0, "R8 write dropped");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(150000 * 2 * HALF);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule